// File: doc/BRIEF.md
# Modulo Lane Steering Stage with Collision Stall

This block sits in front of a bank of parallel sorting lanes. Each cycle it can accept a group of up to `LANES` tag/data entries. It sends every entry to the lane picked by the low bits of its tag: lane = tag mod `LANES`, with `LANES` a power of two and at least two. When the tags of a group are spread evenly, the whole group is delivered in a single cycle. Because of this spread, no lane fills much faster than the others.

An accepted group is held in a register stage. Every lane takes at most one entry per cycle. When several held entries target the same lane, the one with the lowest input index goes first, and the others follow in later cycles in index order. A lane that signals full receives nothing, and its entries wait. The input handshake `in_ready` is high only when every held entry leaves in the current cycle. A group therefore occupies the stage for as many cycles as the largest number of its entries bound for one lane, and a stall holds off the next group.

Top module: `modulo_lane_steer`

## Requirements
- R1: After reset, no lane insert is valid and `in_ready` is 1.
- R2: An entry is only ever presented on lane `tag[SEL_W-1:0]`, where `SEL_W = log2(LANES)`. Input slot i sits at bits `[i*TAG_W +: TAG_W]` of `in_tag`, and lane l uses the same slice of `lane_tag`. The data fields are laid out the same way with `DATA_W`.
- R3: A group accepted at a rising edge (`in_ready` high) is presented on the lane outputs from the next cycle onward, with its tag and data unchanged.
- R4: A group whose valid entries all map to different lanes leaves in one cycle while `in_ready` stays high, so groups can follow each other every cycle.
- R5: Among held entries bound for the same lane, the lowest input index is issued first. The rest follow in successive cycles in ascending index order.
- R6: `in_ready` is 0 in every cycle in which some held entry remains after that cycle's issue. A group with no full lane takes exactly as many cycles as its largest per-lane entry count.
- R7: A lane with `lane_full` high gets no valid insert. Its entries stay held and keep `in_ready` low until the lane is no longer full.
- R8: Input slots whose `in_valid` bit is 0 are never issued and do not compete for a lane.
- R9: Inputs presented while `in_ready` is 0 are ignored. They are never issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | LANES | Per-slot valid of the offered group |
| in_tag | input | LANES*TAG_W | Slot tags, slot i at `[i*TAG_W +: TAG_W]` |
| in_data | input | LANES*DATA_W | Slot data, slot i at `[i*DATA_W +: DATA_W]` |
| in_ready | output | 1 | Group is taken at this edge; low while a collision or a full lane leaves entries held |
| lane_full | input | LANES | Per-lane back-pressure; a full lane gets no insert |
| lane_valid | output | LANES | Per-lane insert strobe |
| lane_tag | output | LANES*TAG_W | Per-lane insert tag |
| lane_data | output | LANES*DATA_W | Per-lane insert data |

## Verification
A group is taken at the edge where `in_ready` is high. Its first issue is visible in the cycle after that edge, and issue k of a colliding lane appears k cycles later. `in_ready` and the lane strobes respond at once to `lane_full`, because they are combinational from the held entries. The bench drives inputs on the falling edge and samples one time unit later. Each check is tied to the cycle index counted from acceptance, so the expected lane, tag, data and ready values come from a per-cycle model of the group.

// File: rtl/modsteer_pkg.sv
package modsteer_pkg;
  // Default geometry of the steering stage.
  localparam int unsigned DEF_LANES  = 4;
  localparam int unsigned DEF_TAG_W  = 8;
  localparam int unsigned DEF_DATA_W = 8;
endpackage

// File: rtl/modsteer_hold.sv
// Holding register for one input group; entries are cleared as they issue.
module modsteer_hold #(
  parameter int unsigned LANES  = modsteer_pkg::DEF_LANES,
  parameter int unsigned TAG_W  = modsteer_pkg::DEF_TAG_W,
  parameter int unsigned DATA_W = modsteer_pkg::DEF_DATA_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [LANES-1:0]          new_vld,
  input  logic [LANES*TAG_W-1:0]    new_tag,
  input  logic [LANES*DATA_W-1:0]   new_data,
  input  logic [LANES-1:0]          issued,
  output logic [LANES-1:0]          vld_q,
  output logic [LANES*TAG_W-1:0]    tag_q,
  output logic [LANES*DATA_W-1:0]   data_q
);
  logic [LANES-1:0] vld_d;

  always_comb begin
    if (load) vld_d = new_vld;
    else      vld_d = vld_q & ~issued;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // Payload registers: clock-enabled, no reset needed.
  always_ff @(posedge clk) begin
    if (load) begin
      tag_q  <= new_tag;
      data_q <= new_data;
    end
  end

  // R9
  no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ((vld_q & ~$past(vld_q)) == '0));
endmodule

// File: rtl/modsteer_pick.sv
// Per-lane pick: the lowest-index requester wins unless the lane is full.
module modsteer_pick #(
  parameter int unsigned LANES = modsteer_pkg::DEF_LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] req,
  input  logic             full,
  output logic [LANES-1:0] grant,
  output logic             valid
);
  logic [LANES-1:0] lowest;

  always_comb begin
    lowest = req & (~req + 1'b1);
    grant  = full ? '0 : lowest;
    valid  = |grant;
  end

  // R7
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !valid);
  // R5
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R5
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((req & (grant - 1'b1)) == '0));
endmodule

// File: rtl/modulo_lane_steer.sv
// Routes a parallel group to lanes by tag modulo LANES, stalling on collisions.
module modulo_lane_steer #(
  parameter int unsigned LANES  = modsteer_pkg::DEF_LANES,
  parameter int unsigned TAG_W  = modsteer_pkg::DEF_TAG_W,
  parameter int unsigned DATA_W = modsteer_pkg::DEF_DATA_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES-1:0]          in_valid,
  input  logic [LANES*TAG_W-1:0]    in_tag,
  input  logic [LANES*DATA_W-1:0]   in_data,
  output logic                      in_ready,
  input  logic [LANES-1:0]          lane_full,
  output logic [LANES-1:0]          lane_valid,
  output logic [LANES*TAG_W-1:0]    lane_tag,
  output logic [LANES*DATA_W-1:0]   lane_data
);
  localparam int unsigned SEL_W = $clog2(LANES);

  logic [LANES-1:0]        pend_vld;
  logic [LANES-1:0]        issued;
  logic [LANES*TAG_W-1:0]  pend_tag;
  logic [LANES*DATA_W-1:0] pend_data;
  logic [LANES-1:0]        req   [LANES];
  logic [LANES-1:0]        grant [LANES];

  // Ready only when nothing stays held past this cycle.
  assign in_ready = ~|(pend_vld & ~issued);

  modsteer_hold #(.LANES(LANES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(in_ready),
    .new_vld(in_valid), .new_tag(in_tag), .new_data(in_data),
    .issued(issued), .vld_q(pend_vld), .tag_q(pend_tag), .data_q(pend_data)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [TAG_W-1:0]  sel_tag;
    logic [DATA_W-1:0] sel_data;

    always_comb begin
      for (int i = 0; i < LANES; i++)
        req[l][i] = pend_vld[i] &&
                    (pend_tag[i*TAG_W +: SEL_W] == SEL_W'(l));
    end

    modsteer_pick #(.LANES(LANES)) u_pick (
      .clk(clk), .rst_n(rst_n), .req(req[l]), .full(lane_full[l]),
      .grant(grant[l]), .valid(lane_valid[l])
    );

    always_comb begin
      sel_tag  = '0;
      sel_data = '0;
      for (int i = 0; i < LANES; i++) begin
        if (grant[l][i]) begin
          sel_tag  = sel_tag  | pend_tag[i*TAG_W +: TAG_W];
          sel_data = sel_data | pend_data[i*DATA_W +: DATA_W];
        end
      end
    end

    assign lane_tag[l*TAG_W +: TAG_W]    = sel_tag;
    assign lane_data[l*DATA_W +: DATA_W] = sel_data;

    // R2
    lane_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lane_valid[l] |-> (lane_tag[l*TAG_W +: SEL_W] == SEL_W'(l)));
  end

  always_comb begin
    issued = '0;
    for (int l = 0; l < LANES; l++) issued = issued | grant[l];
  end

  // R6
  stall_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && lane_full == '0) |=>
      ($countones(pend_vld) < $past($countones(pend_vld))));
endmodule

// File: tb/tb_modulo_lane_steer.sv
module tb_modulo_lane_steer;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NL = 4;
  localparam int unsigned TW = 8;
  localparam int unsigned DW = 8;
  localparam int unsigned NV = 7;
  // {valid mask[35:32], tag of slot 3, slot 2, slot 1, slot 0}
  localparam logic [35:0] VEC [NV] = '{
    {4'hF, 8'd10,  8'd3,   8'd4,   8'd13},
    {4'hF, 8'd6,   8'd1,   8'd5,   8'd7},
    {4'hF, 8'd13,  8'd9,   8'd5,   8'd1},
    {4'hF, 8'd5,   8'd1,   8'd4,   8'd0},
    {4'h5, 8'd2,   8'd3,   8'd12,  8'd8},
    {4'hF, 8'd7,   8'd10,  8'd6,   8'd2},
    {4'hE, 8'd255, 8'd254, 8'd253, 8'd0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [NL-1:0]    in_valid;
  logic [NL*TW-1:0] in_tag;
  logic [NL*DW-1:0] in_data;
  logic             in_ready;
  logic [NL-1:0]    lane_full;
  logic [NL-1:0]    lane_valid;
  logic [NL*TW-1:0] lane_tag;
  logic [NL*DW-1:0] lane_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modulo_lane_steer #(.LANES(NL), .TAG_W(TW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
    .in_data(in_data), .in_ready(in_ready), .lane_full(lane_full),
    .lane_valid(lane_valid), .lane_tag(lane_tag), .lane_data(lane_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_chk(input string req);
    #1;
    chk(lane_valid == '0, req, 64'(lane_valid), 64'h0);
    chk(in_ready == 1'b1, req, 64'(in_ready), 64'h1);
  endtask

  task automatic run_vec(input int v);
    logic [3:0] mask;
    int cnt [NL];
    int mx;
    mask = VEC[v][35:32];
    mx = 0;
    for (int l = 0; l < NL; l++) cnt[l] = 0;
    for (int i = 0; i < NL; i++)
      if (mask[i]) cnt[VEC[v][i*TW +: 2]]++;
    for (int l = 0; l < NL; l++) if (cnt[l] > mx) mx = cnt[l];
    in_valid = mask;
    in_tag   = VEC[v][31:0];
    for (int i = 0; i < NL; i++) in_data[i*DW +: DW] = 8'(v*16 + i);
    cyc();
    for (int k = 0; k < mx; k++) begin
      if (k < mx - 1) begin
        // R9: garbage while stalled, must never appear
        in_valid = 4'hF; in_tag = 32'h03020100; in_data = 32'hEEEEEEEE;
      end else begin
        in_valid = '0;
      end
      #1;
      for (int l = 0; l < NL; l++) begin
        bit ev; logic [7:0] et, ed; int c;
        ev = 1'b0; et = '0; ed = '0; c = 0;
        for (int i = 0; i < NL; i++)
          if (mask[i] && VEC[v][i*TW +: 2] == 2'(l)) begin
            if (c == k) begin ev = 1'b1; et = VEC[v][i*TW +: TW]; ed = 8'(v*16 + i); end
            c++;
          end
        chk(lane_valid[l] == ev, (mask != 4'hF) ? "R8" : (k > 0 ? "R5" : "R3"),
            64'(lane_valid[l]), 64'(ev));
        if (ev) begin
          chk(lane_tag[l*TW +: TW] == et, "R2", 64'(lane_tag[l*TW +: TW]), 64'(et));
          chk(lane_data[l*DW +: DW] == ed, "R3", 64'(lane_data[l*DW +: DW]), 64'(ed));
        end
      end
      chk(in_ready == (k == mx - 1), "R6", 64'(in_ready), 64'(k == mx - 1));
      cyc();
    end
    idle_chk("R9");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = '0; in_tag = '0; in_data = '0; lane_full = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    idle_chk("R1");
    @(negedge clk);

    for (int v = 0; v < NV; v++) run_vec(v);

    // R4: two conflict-free groups back to back
    in_valid = 4'hF; in_tag = {8'd10, 8'd3, 8'd4, 8'd13}; in_data = 32'hA3A2A1A0;
    cyc();
    in_tag = {8'd3, 8'd2, 8'd1, 8'd0}; in_data = 32'hB3B2B1B0;
    #1;
    chk(lane_tag[0 +: 8] == 8'd4 && lane_data[0 +: 8] == 8'hA1, "R4",
        64'(lane_data[0 +: 8]), 64'hA1);
    chk(in_ready == 1'b1, "R4", 64'(in_ready), 64'h1);
    cyc();
    in_valid = '0;
    #1;
    chk(lane_valid == 4'hF, "R4", 64'(lane_valid), 64'hF);
    chk(lane_data[24 +: 8] == 8'hB3 && lane_tag[24 +: 8] == 8'd3, "R4",
        64'(lane_data[24 +: 8]), 64'hB3);
    cyc();
    idle_chk("R4");

    // R7: lane 2 full holds its entries and the stall
    lane_full = 4'b0100;
    in_valid = 4'hF; in_tag = {8'd3, 8'd1, 8'd6, 8'd2}; in_data = 32'hC3C2C1C0;
    cyc();
    in_valid = '0;
    #1;
    chk(lane_valid == 4'b1010, "R7", 64'(lane_valid), 64'hA);
    chk(in_ready == 1'b0, "R7", 64'(in_ready), 64'h0);
    cyc();
    #1;
    chk(lane_valid == 4'b0000, "R7", 64'(lane_valid), 64'h0);
    chk(in_ready == 1'b0, "R7", 64'(in_ready), 64'h0);
    lane_full = '0;
    #1;
    chk(lane_valid == 4'b0100 && lane_data[16 +: 8] == 8'hC0, "R7",
        64'(lane_data[16 +: 8]), 64'hC0);
    chk(in_ready == 1'b0, "R6", 64'(in_ready), 64'h0);
    cyc();
    #1;
    chk(lane_valid == 4'b0100 && lane_tag[16 +: 8] == 8'd6, "R5",
        64'(lane_tag[16 +: 8]), 64'd6);
    chk(in_ready == 1'b1, "R6", 64'(in_ready), 64'h1);
    cyc();
    idle_chk("R7");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule